// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block lets logic running on the system clock use an external 128K x 8 asynchronous static RAM. A client hands it one read or one write at a time over a valid/ready request channel. The controller then sequences the active-low chip-enable, write-enable and output-enable strobes, holds the address, and drives the shared 8-bit data bus only while it writes. Read results come back on a response channel that has no back-pressure: a one-cycle valid pulse with the byte beside it. The request side follows valid/ready rules. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from acceptance until the bus access has fully finished, so a client can hold a request with `req_valid` high for as long as it needs. The response side cannot be stalled, so the client must take `rsp_rdata` in the cycle `rsp_valid` is high.

Every phase length comes from a speed-grade parameter (10, 12 or 15 ns) and the clock period in nanoseconds. Each interval is rounded up to whole clock cycles, never less than one. A static pin picks one of two write styles. In one, output enable stays high during writes. In the other, it stays low. In the second style the write pulse is stretched, and the controller waits until the device has released the bus before it drives data. The data bus is split into an output value, an output-enable and an input value. This lets a pad ring or a board-level tristate buffer join them.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A read asserts `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 in each of its cycles. `mem_we_n` is never 0 while `mem_ce_n` is 1.
- R3: A read holds its phase for max(ceil(tRC), ceil(tAA), ceil(tAOE)) cycles (2 at the defaults). `rsp_valid` is a single-cycle pulse seen in the third cycle after the accepting edge at the defaults, with the captured byte on `rsp_rdata`.
- R4: The write pulse (`mem_we_n`=0) lasts max(ceil(tWP), ceil(tAW), ceil(tWC)-2) cycles (2 at the defaults) when `cfg_oe_low`=0. When `cfg_oe_low`=1 it lasts at least ceil(tWHZ)+ceil(tDW) cycles (3 at the defaults).
- R5: The controller drives `mem_dq_o` (`mem_dq_oe`=1) only inside a write, and never while the device may drive (`mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1). With `cfg_oe_low`=0 it drives from the setup cycle through the recovery cycle (4 cycles). With `cfg_oe_low`=1 it drives only from pulse cycle ceil(tWHZ) to the end of the pulse (2 cycles).
- R6: A write accepted in the cycle right after a read ends passes through ceil(tOHZ) extra turnaround cycles. Both enables stay high there, so `mem_ce_n` stays high for 2 cycles at the defaults. Write-after-write and write-after-read-later see no extra cycle (gap of 1).
- R7: `mem_addr` is constant while `mem_ce_n` is 0. Chip enable falls one cycle before write enable falls and rises one cycle after write enable rises.
- R8: `req_ready` is 0 while an access is in progress. A request held valid during that time is not taken until the access ends, and each acceptance produces exactly one bus access with the fields present at its accepting edge.
- R9: A byte written to any address, including 0x00000 and 0x1FFFF and in either write style, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_oe_low | input | 1 | Write style: 1 keeps output enable low during writes; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Single-cycle read result strobe |
| rsp_rdata | output | 8 | Read result |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Data seen on the bus |

## Verification
At the 5 ns clock with the 10 ns grade, the read response is due in the third cycle after the accepting edge. A write occupies four bus cycles with output enable high and five with it low. The idle gap before a write is one cycle, or two right after a read. Each scenario task drives inputs on the falling edge. It then counts falling edges from the accepting edge and compares the cycle index where `rsp_valid` appears, and the number of cycles each strobe and the data drive stay active, against these derived counts. A falling-edge monitor records the length of every chip-enable-high run and any bus contention, so the turnaround and drive window checks read exact cycle counts and never a settled end state.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_RD, ST_WSET, ST_WPULSE, ST_WREC
  } phase_e;

  typedef enum int {
    P_RC, P_AA, P_AOE, P_WC, P_WP, P_AW, P_DW, P_WHZ, P_OHZ
  } tparam_e;

  // Minimum interval in ns for a speed grade (10, 12 or 15).
  function automatic int grade_ns(input int grade, input tparam_e p);
    int v;
    case (p)
      P_AOE:       v = (grade == 10) ? 6 : 7;
      P_WP, P_AW:  v = (grade == 10) ? 8 : (grade == 12) ? 10 : 11;
      P_DW:        v = (grade == 10) ? 6 : (grade == 12) ? 7 : 8;
      P_WHZ,
      P_OHZ:       v = (grade == 10) ? 5 : (grade == 12) ? 6 : 7;
      default:     v = grade;
    endcase
    return v;
  endfunction

  // Round an interval up to whole clock cycles, at least one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_wdata,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (take_wdata) dq_out <= wdata;
      if (capture)    rdata  <= dq_in;
      rvalid <= capture;
    end
  end

  assign dq_oe = drive;
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int GRADE_NS = 10,
  parameter int CLK_NS   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_oe_low,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // Phase lengths in cycles
  localparam int RD_CYC    = imax(imax(ns_to_cyc(grade_ns(GRADE_NS, P_RC), CLK_NS),
                                       ns_to_cyc(grade_ns(GRADE_NS, P_AA), CLK_NS)),
                                  ns_to_cyc(grade_ns(GRADE_NS, P_AOE), CLK_NS));
  localparam int WC_CYC    = ns_to_cyc(grade_ns(GRADE_NS, P_WC), CLK_NS);
  localparam int WHZ_CYC   = ns_to_cyc(grade_ns(GRADE_NS, P_WHZ), CLK_NS);
  localparam int DW_CYC    = ns_to_cyc(grade_ns(GRADE_NS, P_DW), CLK_NS);
  localparam int TA_CYC    = ns_to_cyc(grade_ns(GRADE_NS, P_OHZ), CLK_NS);
  // setup and recovery take one cycle each, the pulse covers the rest of tWC
  localparam int PULSE_OEH = imax(imax(ns_to_cyc(grade_ns(GRADE_NS, P_WP), CLK_NS),
                                       ns_to_cyc(grade_ns(GRADE_NS, P_AW), CLK_NS)),
                                  WC_CYC - 2);
  localparam int PULSE_OEL = imax(PULSE_OEH, WHZ_CYC + DW_CYC);
  localparam int MAX_CYC   = imax(imax(RD_CYC, PULSE_OEL), TA_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  // in OE-low style, drive once the remaining count falls to this value
  localparam int DRV_LIM   = PULSE_OEL - 1 - WHZ_CYC;

  phase_e             st_q, st_d;
  logic [ADDR_W-1:0]  addr_q;
  logic               oel_q;
  logic               prev_rd_q;
  logic               accept;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic [CNT_W-1:0]   tmr_cnt;
  logic               tmr_last;
  logic               capture;
  logic               drive;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        if (req_write) begin
          if (prev_rd_q) begin
            st_d     = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TA_CYC - 1);
          end else begin
            st_d = ST_WSET;
          end
        end else begin
          st_d     = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RD_CYC - 1);
        end
      end
      ST_TURN: if (tmr_last) st_d = ST_WSET;
      ST_WSET: begin
        st_d     = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = oel_q ? CNT_W'(PULSE_OEL - 1) : CNT_W'(PULSE_OEH - 1);
      end
      ST_WPULSE: if (tmr_last) st_d = ST_WREC;
      ST_WREC:   st_d = ST_IDLE;
      ST_RD: if (tmr_last) begin
        st_d    = ST_IDLE;
        capture = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      oel_q     <= 1'b0;
      prev_rd_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      prev_rd_q <= capture;
      if (accept) begin
        addr_q <= req_addr;
        oel_q  <= cfg_oe_low;
      end
    end
  end

  // Strobe decode from the registered phase
  logic in_write;
  assign in_write = (st_q == ST_WSET) || (st_q == ST_WPULSE) || (st_q == ST_WREC);
  assign mem_ce_n = !(in_write || (st_q == ST_RD));
  assign mem_we_n = (st_q != ST_WPULSE);
  assign mem_oe_n = !((st_q == ST_RD) || (in_write && oel_q));
  assign mem_addr = addr_q;

  always_comb begin
    drive = 1'b0;
    if (in_write) begin
      if (!oel_q)                   drive = 1'b1;
      else if (st_q == ST_WPULSE)   drive = (tmr_cnt <= CNT_W'(DRV_LIM));
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .last     (tmr_last)
  );

  sram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_wdata (accept && req_write),
    .wdata      (req_wdata),
    .drive      (drive),
    .capture    (capture),
    .dq_in      (mem_dq_i),
    .dq_out     (mem_dq_o),
    .dq_oe      (mem_dq_oe),
    .rdata      (rsp_rdata),
    .rvalid     (rsp_valid)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  // R2
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe);

  // R6
  release_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_we_n) |=> !mem_dq_oe);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R7
  ce_leads_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));

  // R7
  ce_trails_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_oe_low = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_oe_low(cfg_oe_low),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory stub
  logic [7:0] mem [int unsigned];
  logic       dev_drive;
  bit         in_wp = 0, wp_ok = 0;
  logic [7:0] wp_data;
  logic [16:0] wp_addr;

  function automatic logic [7:0] stub_rd(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hA5;
  endfunction

  assign dev_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i  = dev_drive ? stub_rd(mem_addr) : 8'h00;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      in_wp   = 1;
      wp_ok   = mem_dq_oe;
      wp_data = mem_dq_o;
      wp_addr = mem_addr;
    end else if (in_wp) begin
      if (wp_ok) mem[int'(wp_addr)] = wp_data;
      in_wp = 0;
    end
  end

  // Bus monitor
  int idle_run = 0, last_gap = 0, contention = 0, enc_err = 0, ce_falls = 0;
  bit prev_ce_n = 1;
  always @(negedge clk) if (rst_n) begin
    if (dev_drive && mem_dq_oe) contention++;
    if (!mem_we_n && mem_ce_n) enc_err++;
    if (mem_ce_n) idle_run++;
    else begin
      if (idle_run != 0) last_gap = idle_run;
      idle_run = 0;
    end
    if (prev_ce_n && !mem_ce_n) ce_falls++;
    prev_ce_n = mem_ce_n;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_accept();
    bit r;
    do begin
      r = req_ready;
      @(negedge clk);
    end while (!r);
  endtask

  int w_we, w_drv, w_ce, w_abad, w_dbad;
  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit oel);
    cfg_oe_low = oel; req_write = 1; req_addr = a; req_wdata = d; req_valid = 1;
    wait_accept();
    req_valid = 0;
    w_we = 0; w_drv = 0; w_ce = 0; w_abad = 0; w_dbad = 0;
    while (!req_ready) begin
      if (!mem_we_n) w_we++;
      if (mem_dq_oe) begin w_drv++; if (mem_dq_o != d) w_dbad++; end
      if (!mem_ce_n) begin w_ce++; if (mem_addr != a) w_abad++; end
      @(negedge clk);
    end
  endtask

  int r_lat, r_enc, r_rdy;
  logic [7:0] r_data;
  task automatic do_read(input logic [16:0] a);
    req_write = 0; req_addr = a; req_valid = 1;
    wait_accept();
    req_valid = 0;
    r_lat = 1; r_enc = 0; r_rdy = 0;
    while (!rsp_valid && r_lat < 50) begin
      if (!(mem_ce_n == 0 && mem_oe_n == 0 && mem_we_n == 1)) r_enc++;
      if (req_ready) r_rdy++;
      @(negedge clk);
      r_lat++;
    end
    r_data = rsp_rdata;
  endtask

  task automatic t_reset_state();
    // R1
    chk("R1", "idle pins {rdy,ce_n,we_n,oe_n,dq_oe,rsp}",
        int'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}), 'b111100);
  endtask

  task automatic t_write_read();
    do_write(17'h00000, 8'h3C, 0);
    chk("R4", "we low cycles, oe high style", w_we, 2);
    chk("R5", "drive cycles, oe high style", w_drv, 4);
    chk("R5", "driven data mismatches", w_dbad, 0);
    chk("R7", "address changes while selected", w_abad, 0);
    do_write(17'h1FFFF, 8'hC3, 0);
    do_write(17'h0ABCD, 8'h5A, 0);
    chk("R6", "gap write after write", last_gap, 1);
    do_read(17'h00000);
    chk("R3", "read response cycle", r_lat, 3);
    chk("R2", "read strobe encoding errors", r_enc, 0);
    chk("R8", "ready high while busy", r_rdy, 0);
    chk("R9", "data at 0x00000", int'(r_data), 'h3C);
    @(negedge clk);
    chk("R3", "response pulse width", int'(rsp_valid), 0);
    do_read(17'h1FFFF);
    chk("R9", "data at 0x1FFFF", int'(r_data), 'hC3);
  endtask

  task automatic t_turnaround();
    do_read(17'h0ABCD);
    chk("R9", "data at 0x0ABCD", int'(r_data), 'h5A);
    do_write(17'h00100, 8'h77, 0);
    chk("R6", "gap write right after read", last_gap, 2);
    do_read(17'h00100);
    chk("R6", "gap read after write", last_gap, 1);
    chk("R9", "data at 0x00100", int'(r_data), 'h77);
  endtask

  task automatic t_oe_low_write();
    do_write(17'h02222, 8'h99, 1);
    chk("R4", "we low cycles, oe low style", w_we, 3);
    chk("R5", "drive cycles, oe low style", w_drv, 2);
    chk("R7", "selected cycles, oe low style", w_ce, 5);
    chk("R7", "address changes, oe low style", w_abad, 0);
    do_read(17'h02222);
    chk("R9", "data after oe low write", int'(r_data), 'h99);
  endtask

  task automatic t_busy_hold();
    int falls0, abad;
    falls0 = ce_falls;
    cfg_oe_low = 0; req_write = 1; req_addr = 17'h00333; req_wdata = 8'h11; req_valid = 1;
    wait_accept();
    req_addr = 17'h00444; req_wdata = 8'h22;   // held valid while busy
    abad = 0;
    while (!req_ready) begin
      if (!mem_ce_n && mem_addr != 17'h00333) abad++;
      @(negedge clk);
    end
    chk("R8", "address taken from accepting edge", abad, 0);
    wait_accept();
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    chk("R8", "bus accesses for two acceptances", ce_falls - falls0, 2);
    do_read(17'h00333);
    chk("R8", "first held request data", int'(r_data), 'h11);
    do_read(17'h00444);
    chk("R8", "second held request data", int'(r_data), 'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_write_read();
    t_turnaround();
    t_oe_low_write();
    t_busy_hold();
    chk("R5", "contention cycles", contention, 0);
    chk("R2", "write enable without chip enable", enc_err, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule